// File: doc/BRIEF.md
# T1 Loop Code Payload Generator

This block sits in a T1 transmit path and, on command, replaces the payload of each 193-bit frame with a repeating in-band loopback code. A frame holds one framing bit followed by 192 payload bits. The framing bit is marked by a strobe that travels with the data. Two plain control inputs choose the code. The loop-up command sends the five-bit pattern 00001 over and over. The loop-down command sends the three-bit pattern 001 over and over. Framing bits always pass through untouched, so the far end keeps frame lock while it watches for the code.

The code phase moves forward only on payload bits. The framing bit holds it, so the pattern runs on across frame boundaries as one continuous sequence and is not restarted at each frame. Whenever the selected code changes, the pattern starts again at phase zero. Asking for both codes at once is illegal. In that case the block passes data through unchanged and raises an error flag.

The serial data flows through a valid/ready stream, one bit per beat, with one register stage. A beat is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output beat is held unchanged. The control inputs and the error flag are plain level signals.

Top module: `t1_loopcode_gen`

## Requirements
- R1: With both controls low, every accepted beat appears at `out_bit` unchanged, one clock after it is accepted.
- R2: With only `code_up` high, accepted payload beats (`in_fbit`=0) are replaced by the repeating sequence 0,0,0,0,1, sent in that order.
- R3: With only `code_dn` high, accepted payload beats are replaced by the repeating sequence 0,0,1, sent in that order.
- R4: A beat accepted with `in_fbit`=1 is sent with its own `in_bit` value and with `out_fbit`=1, whatever the control inputs are.
- R5: The code phase does not move on a framing beat. It carries on across frames without restarting.
- R6: When the selected mode changes (idle, loop-up, loop-down), the next payload beat starts the new code at its first bit (phase zero).
- R7: With both controls high, payload passes through unchanged. `ctl_err` is 1 from the clock after both controls are high, and it returns to 0 on the clock after they are no longer both high.
- R8: Beats come out in order, one register stage after acceptance. `in_ready` = !`out_valid` || `out_ready`. While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_bit` and `out_fbit` hold steady.
- R9: During and right after reset, `out_valid`=0 and `ctl_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can accept a beat |
| in_bit | input | 1 | Input serial data bit |
| in_fbit | input | 1 | Marks the beat as the framing bit (frame bit 0) |
| code_up | input | 1 | Send the loop-up code |
| code_dn | input | 1 | Send the loop-down code |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_bit | output | 1 | Output line bit |
| out_fbit | output | 1 | Output beat is the framing bit |
| ctl_err | output | 1 | Both controls are set (illegal) |

## Verification
Two functions can fall in the same cycle here: a framing beat, which must pass through while holding the code phase, and a code restart after a control change. The bench changes the controls just before the framing beat at the start of a frame. It then checks that the framing bit still carries its input value and that the first payload bit after it is phase zero of the new code. Back-pressure can also stall the output in the same cycle as either of these events. To provoke this, the random stall pattern stays on across those frames. The scoreboard, whose expected codes are worked out from the pattern definitions alone, judges every transferred beat. A separate check confirms that the held beat does not change during each stall.

// File: rtl/t1lc_pkg.sv
package t1lc_pkg;
  typedef enum logic [1:0] {
    LC_PASS = 2'd0,
    LC_UP   = 2'd1,
    LC_DN   = 2'd2
  } lc_mode_e;

  localparam int unsigned LC_NUM_CODES = 2;
endpackage

// File: rtl/t1lc_mode_dec.sv
module t1lc_mode_dec
  import t1lc_pkg::*;
(
  input  logic     code_up,
  input  logic     code_dn,
  output lc_mode_e mode,
  output logic     illegal
);
  always_comb begin
    illegal = code_up & code_dn;
    unique case ({code_up, code_dn})
      2'b10:   mode = LC_UP;
      2'b01:   mode = LC_DN;
      default: mode = LC_PASS;
    endcase
  end
endmodule

// File: rtl/t1lc_phase_seq.sv
module t1lc_phase_seq
  import t1lc_pkg::*;
#(
  parameter int unsigned UP_LEN = 5,
  parameter int unsigned DN_LEN = 3,
  localparam int unsigned MAX_LEN = (UP_LEN > DN_LEN) ? UP_LEN : DN_LEN,
  localparam int unsigned PHW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  lc_mode_e mode,
  input  logic     step,
  output logic     code_bit
);
  localparam int unsigned CODE_LEN [LC_NUM_CODES] = '{UP_LEN, DN_LEN};

  lc_mode_e       mode_q;
  logic [PHW-1:0] phase_q;
  logic [PHW-1:0] cur_phase;
  logic           restart;
  logic [LC_NUM_CODES-1:0] at_last;
  logic [LC_NUM_CODES-1:0] sel;

  assign restart   = (mode != mode_q);
  assign cur_phase = restart ? '0 : phase_q;
  assign sel       = {mode == LC_DN, mode == LC_UP};

  // Each code is (LEN-1) zeros followed by a single one.
  for (genvar k = 0; k < LC_NUM_CODES; k++) begin : g_code
    assign at_last[k] = (cur_phase == PHW'(CODE_LEN[k] - 1));
  end

  assign code_bit = |(at_last & sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= LC_PASS;
      phase_q <= '0;
    end else begin
      mode_q <= mode;
      if (step && (mode != LC_PASS)) begin
        phase_q <= (|(at_last & sel)) ? '0 : cur_phase + PHW'(1);
      end else if (restart) begin
        phase_q <= '0;
      end
    end
  end
endmodule

// File: rtl/t1lc_out_stage.sv
module t1lc_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  input  logic in_fbit,
  input  logic use_code,
  input  logic code_bit,
  output logic accept,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bit,
  output logic out_fbit
);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      out_fbit  <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_fbit <= in_fbit;
        out_bit  <= (use_code && !in_fbit) ? code_bit : in_bit;
      end
    end
  end
endmodule

// File: rtl/t1_loopcode_gen.sv
module t1_loopcode_gen
  import t1lc_pkg::*;
#(
  parameter int unsigned UP_LEN = 5,
  parameter int unsigned DN_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  input  logic in_fbit,
  input  logic code_up,
  input  logic code_dn,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bit,
  output logic out_fbit,
  output logic ctl_err
);
  lc_mode_e mode;
  logic     illegal;
  logic     code_bit;
  logic     accept;

  t1lc_mode_dec u_dec (
    .code_up (code_up),
    .code_dn (code_dn),
    .mode    (mode),
    .illegal (illegal)
  );

  t1lc_phase_seq #(
    .UP_LEN (UP_LEN),
    .DN_LEN (DN_LEN)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .step     (accept && !in_fbit),
    .code_bit (code_bit)
  );

  t1lc_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_bit    (in_bit),
    .in_fbit   (in_fbit),
    .use_code  (mode != LC_PASS),
    .code_bit  (code_bit),
    .accept    (accept),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_bit   (out_bit),
    .out_fbit  (out_fbit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_err <= 1'b0;
    else        ctl_err <= illegal;
  end
endmodule

// File: rtl/t1lc_checker.sv
module t1lc_checker (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic in_bit,
  input logic in_fbit,
  input logic code_up,
  input logic code_dn,
  input logic out_valid,
  input logic out_ready,
  input logic out_bit,
  input logic out_fbit
);
  logic       acc_up_q;
  logic [2:0] zero_run;

  // Zeros sent in a row while loop-up has been held
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_up_q <= 1'b0;
      zero_run <= '0;
    end else begin
      acc_up_q <= in_valid && in_ready && !in_fbit && code_up && !code_dn;
      if (!(code_up && !code_dn)) zero_run <= '0;
      else if (acc_up_q)          zero_run <= out_bit ? 3'd0 : zero_run + 3'd1;
    end
  end

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bit) && $stable(out_fbit));

  assert_fbit_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_fbit |=> out_fbit && (out_bit == $past(in_bit)));

  assert_both_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && code_up && code_dn |=> out_bit == $past(in_bit));

  assert_up_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_up_q && code_up && !code_dn && (zero_run == 3'd4) |-> out_bit);

  assert_reset_empty_R9: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind t1_loopcode_gen t1lc_checker u_t1lc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_bit    (in_bit),
  .in_fbit   (in_fbit),
  .code_up   (code_up),
  .code_dn   (code_dn),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_bit   (out_bit),
  .out_fbit  (out_fbit)
);

// File: tb/test_t1_loopcode_gen.sv
module test_t1_loopcode_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_bit = 1'b0, in_fbit = 1'b0;
  logic code_up = 1'b0, code_dn = 1'b0;
  logic out_ready = 1'b1;
  logic in_ready, out_valid, out_bit, out_fbit, ctl_err;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  typedef struct { logic b; logic f; string tag; } exp_t;
  exp_t sb[$];

  // bench model state
  int m_mode = 0;
  int m_phase = 0;
  logic [15:0] data_lfsr = 16'hACE1;
  logic [7:0]  rdy_lfsr = 8'h5B;
  bit stall_en = 0;

  always #4 clk = ~clk;

  t1_loopcode_gen i_t1_loopcode_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .in_fbit(in_fbit), .code_up(code_up), .code_dn(code_dn),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit),
    .out_fbit(out_fbit), .ctl_err(ctl_err)
  );

  task automatic check(input bit ok, input string tag, input logic act, input logic exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Random back-pressure (R8)
  always @(posedge clk) begin
    #1;
    rdy_lfsr = {rdy_lfsr[6:0], rdy_lfsr[7] ^ rdy_lfsr[5] ^ rdy_lfsr[4] ^ rdy_lfsr[3]};
    out_ready = stall_en ? rdy_lfsr[0] : 1'b1;
  end

  // Driver: computes the expected beat from the code definitions
  task automatic send(input logic b, input logic f);
    exp_t e;
    int mode;
    int len;
    bit acc;
    mode = (code_up && !code_dn) ? 1 : (code_dn && !code_up) ? 2 : 0;
    e.tag = "";
    if (mode != m_mode) begin m_mode = mode; m_phase = 0; e.tag = "R6"; end
    if (f) begin
      e.b = b; e.tag = "R4";
    end else if (mode == 0) begin
      e.b = b; e.tag = (code_up && code_dn) ? "R7" : "R1";
    end else begin
      len = (mode == 1) ? 5 : 3;
      e.b = (m_phase == len - 1);
      if (e.tag == "") e.tag = (mode == 1) ? "R2" : "R3";
      m_phase = (m_phase + 1) % len;
    end
    e.f = f;
    in_valid = 1'b1; in_bit = b; in_fbit = f;
    do begin
      @(negedge clk); acc = in_ready;
      if (acc) sb.push_back(e);
      @(posedge clk); #1;
    end while (!acc);
    in_valid = 1'b0;
  endtask

  // One 193-beat frame; framing beat first. R5: phase held on beat 0.
  task automatic send_frame();
    for (int i = 0; i < 193; i++) begin
      data_lfsr = {data_lfsr[14:0], data_lfsr[15] ^ data_lfsr[13] ^ data_lfsr[12] ^ data_lfsr[10]};
      send(data_lfsr[0], i == 0);
    end
  endtask

  task automatic set_ctl(input logic up, input logic dn);
    code_up = up; code_dn = dn;
    @(posedge clk); @(negedge clk);
    check(ctl_err === (up & dn), "R7 ctl_err", ctl_err, up & dn);
    @(posedge clk); #1;
  endtask

  // Monitor: scoreboard compare and stall-hold check
  bit hold_prev = 0;
  logic held_b, held_f;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_prev)
        check(out_valid && out_bit === held_b && out_fbit === held_f,
              "R8 stall hold", out_bit, held_b);
      if (out_valid && out_ready) begin
        if (sb.size() == 0) check(0, "R8 unexpected beat", out_bit, 1'bx);
        else begin
          exp_t e;
          e = sb.pop_front();
          check(out_bit === e.b && out_fbit === e.f, e.tag, out_bit, e.b);
        end
      end
      hold_prev = out_valid && !out_ready;
      held_b = out_bit; held_f = out_fbit;
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(!out_valid, "R9 out_valid in reset", out_valid, 1'b0);
    check(!ctl_err, "R9 ctl_err in reset", ctl_err, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(!out_valid && !ctl_err, "R9 after reset", out_valid, 1'b0);
    check(in_ready, "R8 ready when empty", in_ready, 1'b1);

    send_frame();                 // R1 idle pass-through
    set_ctl(1'b1, 1'b0);          // R2 + R6 restart, at a frame boundary
    send_frame(); send_frame();   // R5 phase runs across frames
    stall_en = 1;                 // R8 back-pressure from here
    set_ctl(1'b0, 1'b1);          // R3 + R6
    send_frame(); send_frame();
    for (int i = 0; i < 7; i++) send(1'b0, 1'b0);   // mid-frame switch
    set_ctl(1'b1, 1'b0);
    for (int i = 0; i < 186; i++) send(1'b1, 1'b0);
    set_ctl(1'b1, 1'b1);          // R7 both set
    send_frame();
    set_ctl(1'b1, 1'b0);          // back to loop-up, restart R6
    send_frame();
    stall_en = 0;
    set_ctl(1'b0, 1'b0);          // R1 again
    send_frame();
    repeat (6) @(posedge clk);
    @(negedge clk);
    check(sb.size() == 0, "R8 all beats delivered", 1'b0, 1'b0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule